// File: doc/BRIEF.md
# Asynchronous Serial Port with Line Break and Pin Takeover

This block is an asynchronous serial transmitter and receiver with a small register interface. Software loads a byte into a transmit holding register, and the transmitter sends it as a frame on the transmit line. The receiver samples the receive line at mid-bit and places each completed byte in a receive holding register. It flags overrun, parity and framing errors.

When the transmitter is disabled, a port direction bit and a port data bit take over the transmit pin. Software uses this to hold the line at mark or to drive a break. Clearing the transmit enable stops a frame in progress at once. The receiver keeps working through a break, so it reports the framing error again after each frame of zeros. An optional mode holds back any new transmission while a receive error is pending. Disabling the receiver leaves the error flags as they are.

Top module: `uart_brk_port`

## Requirements
- R1: While control bit 0 (transmit enable) is 0, `txd_oe_o` equals control bit 4 (port direction) and `txd_o` equals control bit 5 (port data). With direction 0 the pin is released (`txd_oe_o` = 0).
- R2: While transmit enable is 1, `txd_oe_o` is 1 and the idle line is 1.
- R3: A frame has one start bit (0), 8 data bits LSB first, an even parity bit when control bit 2 is 1, and one stop bit (1). Each bit lasts DIV clocks, with DIV = 16 by default.
- R4: Writing address 2 loads the transmit register and clears status bit 0 (transmit empty). The flag returns to 1 when the frame starts.
- R5: Clearing transmit enable aborts the frame at once. The pin follows the port bits from the next cycle, and the aborted frame is not resumed when the transmitter is enabled again.
- R6: With control bit 3 (block on error) set, no frame starts while any of status bits 2, 3 or 4 is 1. The frame starts after those bits are cleared. With control bit 3 clear, frames start regardless of the error bits.
- R7: With control bit 1 (receive enable) set, a received byte is readable at address 3 and sets status bit 1 (receive full).
- R8: A stop bit sampled as 0 sets status bit 4 (framing error), and the byte is still stored. During a break the receiver keeps framing all-zero bytes, so status bit 4 is set again after software clears it.
- R9: With parity on, a received parity bit that does not give even parity sets status bit 3.
- R10: A frame that completes while receive full is set leaves address 3 unchanged and sets status bit 2 (overrun).
- R11: Clearing receive enable does not change status bits 2 to 4. Writing address 1 clears each of status bits 1 to 4 whose written bit is 0, and leaves each bit written as 1 unchanged.
- R12: After reset, control reads 0x00, status reads 0x01 and `txd_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 control, 1 status, 2 transmit, 3 receive) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line level |
| txd_oe_o | output | 1 | Transmit pin output enable |

## Verification
A transmitter that keeps running after its enable falls shows a wrong level on `txd_o` in the very next cycle, because the pin should already follow the port data bit. A stale transmit empty flag shows up within two cycles of a write to the transmit register. A start gate that ignores the error flags shows a start bit on the line within one cycle of the write. Receiver faults show up at the end of the frame's stop bit: a wrong byte at address 3, or a missing error bit, or one set when it should not be.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  parameter int unsigned DATA_W = 8;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_TDR  = 2'd2,
    REG_RDR  = 2'd3
  } reg_addr_e;

  // status bit positions
  localparam int unsigned ST_TDRE = 0;
  localparam int unsigned ST_RDRF = 1;
  localparam int unsigned ST_OVR  = 2;
  localparam int unsigned ST_PER  = 3;
  localparam int unsigned ST_FER  = 4;

  // control register, bit 0 = txen
  typedef struct packed {
    logic dat;
    logic dir;
    logic blk;
    logic par;
    logic rxen;
    logic txen;
  } ctrl_t;
endpackage

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
  parameter int unsigned DIV = 16,
  parameter int unsigned DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          par_en_i,
  input  logic          start_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          line_o
);
  localparam int unsigned FW = DW + 3;
  localparam int unsigned CW = $clog2(DIV);
  localparam int unsigned NW = $clog2(FW + 1);

  logic [FW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic [NW-1:0] left_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
      left_q <= '0;
    end else if (!en_i) begin
      // disable aborts whatever bit is on the line
      busy_q <= 1'b0;
      sh_q   <= '1;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      sh_q   <= par_en_i ? {1'b1, ^data_i, data_i, 1'b0} : {1'b1, 1'b1, data_i, 1'b0};
      cnt_q  <= CW'(DIV - 1);
      left_q <= par_en_i ? NW'(FW - 1) : NW'(FW - 2);
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        cnt_q <= CW'(DIV - 1);
        if (left_q == '0) begin
          busy_q <= 1'b0;
        end else begin
          sh_q   <= {1'b1, sh_q[FW-1:1]};
          left_q <= left_q - 1'b1;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign line_o = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx #(
  parameter int unsigned DIV = 16,
  parameter int unsigned DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          par_en_i,
  input  logic          rxd_i,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          fer_o,
  output logic          per_o
);
  localparam int unsigned CW = $clog2(DIV);
  localparam int unsigned IW = $clog2(DW);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} rx_st_e;

  rx_st_e        st_q;
  logic [1:0]    sync_q;
  logic          rxs;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] sh_q;
  logic          pbit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end
  assign rxs = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      pbit_q <= 1'b0;
      done_o <= 1'b0;
      data_o <= '0;
      fer_o  <= 1'b0;
      per_o  <= 1'b0;
    end else if (!en_i) begin
      st_q   <= S_IDLE;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        // level start detect: a held-low line reframes back to back
        S_IDLE: if (!rxs) begin
          st_q  <= S_START;
          cnt_q <= CW'(DIV / 2 - 1);
        end
        S_START: if (cnt_q == '0) begin
          if (!rxs) begin
            st_q  <= S_DATA;
            cnt_q <= CW'(DIV - 1);
            idx_q <= '0;
          end else begin
            st_q <= S_IDLE;
          end
        end else cnt_q <= cnt_q - 1'b1;
        S_DATA: if (cnt_q == '0) begin
          sh_q  <= {rxs, sh_q[DW-1:1]};
          cnt_q <= CW'(DIV - 1);
          if (idx_q == IW'(DW - 1)) st_q <= par_en_i ? S_PAR : S_STOP;
          else                      idx_q <= idx_q + 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        S_PAR: if (cnt_q == '0) begin
          pbit_q <= rxs;
          cnt_q  <= CW'(DIV - 1);
          st_q   <= S_STOP;
        end else cnt_q <= cnt_q - 1'b1;
        S_STOP: if (cnt_q == '0) begin
          done_o <= 1'b1;
          data_o <= sh_q;
          fer_o  <= !rxs;
          per_o  <= par_en_i && (pbit_q != ^sh_q);
          st_q   <= S_IDLE;
        end else cnt_q <= cnt_q - 1'b1;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_brk_port.sv
module uart_brk_port
  import uart_brk_pkg::*;
#(
  parameter int unsigned DIV = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       rxd_i,
  output logic       txd_o,
  output logic       txd_oe_o
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] tdr_q, rdr_q;
  logic              tdre_q, rdrf_q, ovr_q, per_q, fer_q;

  logic              tx_en, rx_en, blk_en, err_any, stat_wr, tdr_wr, ctrl_wr;
  logic [2:0]        err_flags;
  logic              tx_start, tx_busy, tx_line;
  logic              rx_done, rx_fer, rx_per;
  logic [DATA_W-1:0] rx_data;

  assign tx_en     = ctrl_q.txen;
  assign rx_en     = ctrl_q.rxen;
  assign blk_en    = ctrl_q.blk;
  assign err_flags = {fer_q, per_q, ovr_q};
  assign err_any   = |err_flags;
  assign ctrl_wr   = wr_en_i && (addr_i == REG_CTRL);
  assign stat_wr   = wr_en_i && (addr_i == REG_STAT);
  assign tdr_wr    = wr_en_i && (addr_i == REG_TDR);
  assign tx_start  = tx_en && !tdre_q && !tx_busy && !(blk_en && err_any);

  uart_brk_tx #(.DIV(DIV), .DW(DATA_W)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (tx_en),
    .par_en_i (ctrl_q.par),
    .start_i  (tx_start),
    .data_i   (tdr_q),
    .busy_o   (tx_busy),
    .line_o   (tx_line)
  );

  uart_brk_rx #(.DIV(DIV), .DW(DATA_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (rx_en),
    .par_en_i (ctrl_q.par),
    .rxd_i    (rxd_i),
    .done_o   (rx_done),
    .data_o   (rx_data),
    .fer_o    (rx_fer),
    .per_o    (rx_per)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      tdr_q  <= '0;
      tdre_q <= 1'b1;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(wdata_i[5:0]);
      if (tx_start) tdre_q <= 1'b1;
      if (tdr_wr) begin
        tdr_q  <= wdata_i;
        tdre_q <= 1'b0;
      end
    end
  end

  // status: software clears by writing 0, hardware set wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdr_q  <= '0;
      rdrf_q <= 1'b0;
      ovr_q  <= 1'b0;
      per_q  <= 1'b0;
      fer_q  <= 1'b0;
    end else begin
      if (stat_wr) begin
        if (!wdata_i[ST_RDRF]) rdrf_q <= 1'b0;
        if (!wdata_i[ST_OVR])  ovr_q  <= 1'b0;
        if (!wdata_i[ST_PER])  per_q  <= 1'b0;
        if (!wdata_i[ST_FER])  fer_q  <= 1'b0;
      end
      if (rx_done) begin
        if (rdrf_q) begin
          ovr_q <= 1'b1;
        end else begin
          rdr_q  <= rx_data;
          rdrf_q <= 1'b1;
        end
        if (rx_fer) fer_q <= 1'b1;
        if (rx_per) per_q <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      REG_CTRL: rdata_o = {2'b00, ctrl_q};
      REG_STAT: rdata_o = {3'b000, fer_q, per_q, ovr_q, rdrf_q, tdre_q};
      REG_TDR:  rdata_o = tdr_q;
      default:  rdata_o = rdr_q;
    endcase
  end

  assign txd_o    = tx_en ? tx_line : ctrl_q.dat;
  assign txd_oe_o = tx_en | ctrl_q.dir;
endmodule

// File: rtl/uart_brk_port_chk.sv
module uart_brk_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_en_i,
  input logic       tx_busy_i,
  input logic       blk_i,
  input logic       err_any_i,
  input logic       tdre_i,
  input logic       tdr_wr_i,
  input logic       rx_en_i,
  input logic       rx_done_i,
  input logic       stat_wr_i,
  input logic [2:0] flags_i,
  input logic       rdrf_i,
  input logic [7:0] rdr_i
);
  a_r5_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> !tx_busy_i);

  a_r6_no_start_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_i && err_any_i && !tx_busy_i) |=> !tx_busy_i);

  a_r4_start_sets_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && !tx_busy_i && !tdre_i && !(blk_i && err_any_i) && !tdr_wr_i)
      |=> (tdre_i && tx_busy_i));

  a_r10_ovr_keeps_rdr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && rdrf_i) |=> ($stable(rdr_i) && flags_i[0]));

  a_r11_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_i && !rx_done_i && !stat_wr_i) |=> $stable(flags_i));
endmodule

bind uart_brk_port uart_brk_port_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_en_i   (tx_en),
  .tx_busy_i (tx_busy),
  .blk_i     (blk_en),
  .err_any_i (err_any),
  .tdre_i    (tdre_q),
  .tdr_wr_i  (tdr_wr),
  .rx_en_i   (rx_en),
  .rx_done_i (rx_done),
  .stat_wr_i (stat_wr),
  .flags_i   (err_flags),
  .rdrf_i    (rdrf_q),
  .rdr_i     (rdr_q)
);

// File: tb/uart_brk_port_bench.sv
module uart_brk_port_bench;
  localparam int DIV = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rxd = 1'b1;
  logic       txd, txd_oe;

  int n_tests = 0;
  int n_fail  = 0;
  logic       mon_on = 1'b0;
  logic       par_mode = 1'b0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  uart_brk_port #(.DIV(DIV)) u_uart_brk_port (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rxd_i(rxd), .txd_o(txd), .txd_oe_o(txd_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic send_rx(input logic [7:0] d, input logic par, input logic flip, input logic stop);
    @(negedge clk);
    rxd = 1'b0;
    repeat (DIV) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (DIV) @(negedge clk);
    end
    if (par) begin
      rxd = (^d) ^ flip;
      repeat (DIV) @(negedge clk);
    end
    rxd = stop;
    repeat (DIV) @(negedge clk);
    rxd = 1'b1;
    repeat (DIV) @(negedge clk);
  endtask

  // scoreboard monitor for the transmit line (R3)
  initial begin
    logic [7:0] got, exp;
    logic       st, pb, sp;
    forever begin
      @(negedge clk);
      if (mon_on && txd_oe && !txd) begin
        repeat (DIV / 2) @(negedge clk);
        st = txd;
        for (int i = 0; i < 8; i++) begin
          repeat (DIV) @(negedge clk);
          got[i] = txd;
        end
        pb = 1'b0;
        if (par_mode) begin
          repeat (DIV) @(negedge clk);
          pb = txd;
        end
        repeat (DIV) @(negedge clk);
        sp = txd;
        if (exp_q.size() == 0) begin
          n_tests++; n_fail++;
          $display("FAIL R3: unexpected frame actual %02h expected none", got);
        end else begin
          exp = exp_q.pop_front();
          chk("R3 start bit", {7'd0, st}, 8'h00);
          chk("R3 data", got, exp);
          if (par_mode) chk("R3 parity", {7'd0, pb}, {7'd0, ^exp});
          chk("R3 stop bit", {7'd0, sp}, 8'h01);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic wait_tx_done();
    wait (exp_q.size() == 0);
    repeat (DIV * 2) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    int zeros;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R12 reset state
    rd(2'd0, v); chk("R12 ctrl", v, 8'h00);
    rd(2'd1, v); chk("R12 status", v, 8'h01);
    chk("R12 oe", {7'd0, txd_oe}, 8'h00);

    // R1 port takeover
    wr(2'd0, 8'h30);
    chk("R1 mark oe", {7'd0, txd_oe}, 8'h01);
    chk("R1 mark level", {7'd0, txd}, 8'h01);
    wr(2'd0, 8'h10);
    chk("R1 break level", {7'd0, txd}, 8'h00);
    wr(2'd0, 8'h00);
    chk("R1 released", {7'd0, txd_oe}, 8'h00);

    // R2 / R3 / R4 transmit, no parity
    wr(2'd0, 8'h33);
    chk("R2 oe", {7'd0, txd_oe}, 8'h01);
    chk("R2 idle", {7'd0, txd}, 8'h01);
    mon_on = 1'b1;
    exp_q.push_back(8'hA5);
    wr(2'd2, 8'hA5);
    rd(2'd1, v); chk("R4 empty cleared", v & 8'h01, 8'h00);
    repeat (2) @(negedge clk);
    rd(2'd1, v); chk("R4 empty on start", v & 8'h01, 8'h01);
    wait_tx_done();

    // R3 with parity
    wr(2'd0, 8'h37); par_mode = 1'b1;
    exp_q.push_back(8'h3C); wr(2'd2, 8'h3C); wait_tx_done();
    exp_q.push_back(8'h01); wr(2'd2, 8'h01); wait_tx_done();
    wr(2'd0, 8'h33); par_mode = 1'b0;

    // R5 abort
    mon_on = 1'b0;
    wr(2'd2, 8'hFF);
    repeat (40) @(negedge clk);
    wr(2'd0, 8'h12);
    chk("R5 break after abort", {txd_oe, txd}, 8'h02);
    repeat (20) @(negedge clk);
    chk("R5 break held", {7'd0, txd}, 8'h00);
    wr(2'd0, 8'h33);
    zeros = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!txd) zeros++;
    end
    chk("R5 no resume", 8'(zeros), 8'h00);
    mon_on = 1'b1;

    // R7 receive
    send_rx(8'h5A, 1'b0, 1'b0, 1'b1);
    rd(2'd1, v); chk("R7 full", v, 8'h03);
    rd(2'd3, v); chk("R7 data", v, 8'h5A);
    wr(2'd1, 8'h00);

    // R9 parity error
    wr(2'd0, 8'h37);
    send_rx(8'h5A, 1'b1, 1'b1, 1'b1);
    rd(2'd1, v); chk("R9 parity flag", v, 8'h0B);
    wr(2'd1, 8'h00);
    send_rx(8'h5B, 1'b1, 1'b0, 1'b1);
    rd(2'd1, v); chk("R9 good parity", v, 8'h03);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h33);

    // R8 framing error, byte kept
    send_rx(8'h81, 1'b0, 1'b0, 1'b0);
    rd(2'd1, v); chk("R8 framing flag", v, 8'h13);
    rd(2'd3, v); chk("R8 data kept", v, 8'h81);
    wr(2'd1, 8'h00);

    // R10 overrun
    send_rx(8'h11, 1'b0, 1'b0, 1'b1);
    send_rx(8'h22, 1'b0, 1'b0, 1'b1);
    rd(2'd1, v); chk("R10 overrun", v, 8'h07);
    rd(2'd3, v); chk("R10 old data", v, 8'h11);

    // R11 flags survive receive disable and write-1
    wr(2'd0, 8'h31);
    repeat (5) @(negedge clk);
    rd(2'd1, v); chk("R11 kept after rx off", v, 8'h07);
    wr(2'd1, 8'hFF);
    rd(2'd1, v); chk("R11 write one keeps", v, 8'h07);
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk("R11 write zero clears", v, 8'h01);
    wr(2'd0, 8'h33);

    // R6 block on error
    wr(2'd0, 8'h3B);
    send_rx(8'h00, 1'b0, 1'b0, 1'b0);
    exp_q.push_back(8'h96);
    wr(2'd2, 8'h96);
    zeros = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!txd) zeros++;
    end
    chk("R6 held line", 8'(zeros), 8'h00);
    rd(2'd1, v); chk("R6 still pending", v & 8'h01, 8'h00);
    wr(2'd1, 8'h00);
    wait_tx_done();
    wr(2'd0, 8'h33);
    send_rx(8'h00, 1'b0, 1'b0, 1'b0);
    exp_q.push_back(8'h69);
    wr(2'd2, 8'h69);
    wait_tx_done();
    rd(2'd1, v); chk("R6 sent despite error", v & 8'h11, 8'h11);
    wr(2'd1, 8'h00);

    // R8 break: repeated framing errors
    rxd = 1'b0;
    repeat (200) @(negedge clk);
    rd(2'd1, v); chk("R8 break framing", v & 8'h10, 8'h10);
    rd(2'd3, v); chk("R8 break data", v, 8'h00);
    wr(2'd1, 8'h00);
    repeat (200) @(negedge clk);
    rd(2'd1, v); chk("R8 break re-flag", v & 8'h10, 8'h10);
    rxd = 1'b1;
    repeat (400) @(negedge clk);
    wr(2'd1, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule